// File: doc/BRIEF.md
# D-PHY Lane Timing Calculator

This block turns a serial lane bit rate, given in Mbps, into the set of per-lane timing counts that a D-PHY transmitter lane needs. From the rate it derives the byte clock (rate × 10^6 / 8) and an escape clock. The escape clock is the byte clock divided by the smallest integer that keeps it at or below 20 MHz. Each nanosecond minimum is then converted into a whole number of byte-clock or escape-clock periods, always rounding up. The HS prepare, zero and trail counts come from a table indexed by rate buckets. The table has separate zero counts for the clock lane and the data lanes.

Two timing variants are supported. In variant 0, lpx is computed from the byte clock. In variant 1, lpx is taken from that variant's own table. A single shared sequential divider carries out every division one after another. A request is accepted on a start strobe, and a one-cycle done pulse marks the moment all twelve output fields are valid. The fields then hold until the next completed request. Writing the fields into lane registers is left to the surrounding logic.

Top module: `dphy_lane_timing`

## Requirements
- R1: While reset is held, and after it is released until the first done, every computed field reads 0 and done is low.
- R2: The byte clock is rate×125000 Hz. The escape divisor is ceil(rate/160) and the escape clock is floor(byte clock / divisor). ta_go, ta_sure and ta_wait are ceil(T × escape clock / 10^9) for T = 240, 120 and 300 ns.
- R3: hs_exit is ceil(120 × rate / 8000), i.e. 120 ns in byte clocks rounded up.
- R4: With UI = floor((1000 + floor(rate/2)) / rate) ns, clk_post is ceil((70 + 52·UI) × rate / 8000) and clk_pre is ceil(8·UI × rate / 8000).
- R5: With variant select 0, lpx is ceil(60 × rate / 8000), reduced by 2 when that value is greater than 2.
- R6: The lookup picks the first row whose maximum rate is greater than or equal to the request, or the last row when none qualifies. hs_prepare and hs_trail come from that row, and so does lpx when the variant select is 1. Variant 0 has 11 rows (110 to 1000 Mbps) and variant 1 has 15 rows (110 to 2000 Mbps); the row contents are listed in the package.
- R7: hs_zero takes the row's clock-lane value when the lane select is 1 and its data-lane value when the lane select is 0.
- R8: Any field whose computed value exceeds its width saturates to all ones. The widths are lpx 6, hs_prepare 7, hs_zero 6, hs_trail 7, hs_exit 5, clk_post 4, clk_pre 4, and ta_go, ta_sure and ta_wait 6 each.
- R9: wakeup_hi always reads 3 and wakeup_lo always reads 255.
- R10: Inputs are sampled when start is seen while the block is idle. A start during a calculation is ignored. done is high for exactly one cycle, and the outputs hold their values between done pulses.
- R11: A rate of 0 is treated as a rate of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a calculation (accepted when idle) |
| rate_mbps_i | input | RATE_W | Lane bit rate in Mbps |
| clk_lane_i | input | 1 | 1 = clock lane, 0 = data lane |
| alt_variant_i | input | 1 | Timing variant select (0 or 1) |
| done_o | output | 1 | One-cycle pulse: fields valid |
| lpx_o | output | 6 | LP transmit period count |
| hs_prepare_o | output | 7 | HS prepare count |
| hs_zero_o | output | 6 | HS zero count |
| hs_trail_o | output | 7 | HS trail count |
| hs_exit_o | output | 5 | HS exit count (byte clocks) |
| clk_post_o | output | 4 | Clock post count (byte clocks) |
| clk_pre_o | output | 4 | Clock pre count (byte clocks) |
| wakeup_hi_o | output | 2 | Wakeup count, upper field |
| wakeup_lo_o | output | 8 | Wakeup count, lower field |
| ta_go_o | output | 6 | Turnaround go count (escape clocks) |
| ta_sure_o | output | 6 | Turnaround sure count (escape clocks) |
| ta_wait_o | output | 6 | Turnaround wait count (escape clocks) |

## Verification
The bound checker watches some properties on every cycle. done must be a single-cycle pulse, and a start that is accepted must not produce done on the next cycle. The outputs may only change together with done. The turnaround counts must stay ordered sure ≤ go ≤ wait, clk_post must never be below clk_pre, and ta_wait must never exceed 6, which is the bound set by the escape clock limit. The exact values can only be shown by the bench scenarios. These cover the rate-bucket boundaries, requests past the last row, the difference between clock-lane and data-lane zero counts, the variant-specific lpx, saturation, the rate-0 clamp, and a start issued mid-calculation.

// File: rtl/dphy_tc_pkg.sv
package dphy_tc_pkg;

    // shared divider width: largest numerator is 300 * 20e6 + 1e9 < 2^34
    localparam int DIV_W = 34;
    typedef logic [DIV_W-1:0] dword_t;

    // clocking constants
    localparam int BYTE_HZ_PER_MBPS = 125000;                 // 1e6 / 8
    localparam int NS_PER_S         = 1000000000;
    localparam int NS_BYTE_DEN      = NS_PER_S / BYTE_HZ_PER_MBPS; // 8000
    localparam int ESC_LIMIT_HZ     = 20000000;
    localparam int ESC_LIMIT_MBPS   = ESC_LIMIT_HZ / BYTE_HZ_PER_MBPS; // 160
    localparam int UI_NUM_NS        = 1000;

    // nanosecond minimums
    localparam int LPX_NS           = 60;
    localparam int HS_EXIT_NS       = 120;
    localparam int CLK_POST_BASE_NS = 70;
    localparam int CLK_POST_UI_MULT = 52;
    localparam int CLK_PRE_UI_MULT  = 8;
    localparam int TA_GO_NS         = 4 * LPX_NS;
    localparam int TA_SURE_NS       = 2 * LPX_NS;
    localparam int TA_WAIT_NS       = 5 * LPX_NS;
    localparam int LPX_TRIM         = 2;

    // field widths
    localparam int W_LPX   = 6;
    localparam int W_PREP  = 7;
    localparam int W_ZERO  = 6;
    localparam int W_TRAIL = 7;
    localparam int W_EXIT  = 5;
    localparam int W_POST  = 4;
    localparam int W_PRE   = 4;
    localparam int W_TA    = 6;
    localparam int W_WAKEH = 2;
    localparam int W_WAKEL = 8;
    localparam logic [W_WAKEH-1:0] WAKE_HI_VAL = 2'd3;
    localparam logic [W_WAKEL-1:0] WAKE_LO_VAL = 8'hFF;

    // lookup sizes
    localparam int ROWS_BASE = 11;
    localparam int ROWS_ALT  = 15;
    localparam int ROWS_MAX  = (ROWS_ALT > ROWS_BASE) ? ROWS_ALT : ROWS_BASE;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ESCDIV, ST_ESCCLK, ST_UI, ST_HSEXIT, ST_CLKPOST,
        ST_CLKPRE, ST_LPX, ST_TAGO, ST_TASURE, ST_TAWAIT
    } step_e;

    typedef struct packed {
        dword_t hs_exit;
        dword_t clk_post;
        dword_t clk_pre;
        dword_t lpx;
        dword_t ta_go;
        dword_t ta_sure;
        dword_t ta_wait;
    } raw_t;

    typedef struct packed {
        logic [15:0] max_rate;
        logic [7:0]  lpx;
        logic [7:0]  prep;
        logic [7:0]  zero_clk;
        logic [7:0]  zero_data;
        logic [7:0]  trail;
    } lut_row_t;

    function automatic lut_row_t lut_row(input logic alt, input int idx);
        lut_row_t r;
        if (!alt) begin
            case (idx)
                0:       r = '{16'd110,  8'h00, 8'h20, 8'h16, 8'h02, 8'h22};
                1:       r = '{16'd150,  8'h00, 8'h06, 8'h16, 8'h03, 8'h45};
                2:       r = '{16'd200,  8'h00, 8'h18, 8'h17, 8'h04, 8'h0b};
                3:       r = '{16'd250,  8'h00, 8'h05, 8'h17, 8'h05, 8'h16};
                4:       r = '{16'd300,  8'h00, 8'h51, 8'h18, 8'h06, 8'h2c};
                5:       r = '{16'd400,  8'h00, 8'h64, 8'h19, 8'h07, 8'h33};
                6:       r = '{16'd500,  8'h00, 8'h20, 8'h1b, 8'h07, 8'h4e};
                7:       r = '{16'd600,  8'h00, 8'h6a, 8'h1d, 8'h08, 8'h3a};
                8:       r = '{16'd700,  8'h00, 8'h3e, 8'h1e, 8'h08, 8'h6a};
                9:       r = '{16'd800,  8'h00, 8'h21, 8'h1f, 8'h09, 8'h29};
                default: r = '{16'd1000, 8'h00, 8'h09, 8'h20, 8'h09, 8'h27};
            endcase
        end else begin
            case (idx)
                0:       r = '{16'd110,  8'h02, 8'h7f, 8'h16, 8'h02, 8'h02};
                1:       r = '{16'd150,  8'h02, 8'h7f, 8'h16, 8'h03, 8'h02};
                2:       r = '{16'd200,  8'h02, 8'h7f, 8'h17, 8'h04, 8'h02};
                3:       r = '{16'd250,  8'h02, 8'h7f, 8'h17, 8'h05, 8'h04};
                4:       r = '{16'd300,  8'h02, 8'h7f, 8'h18, 8'h06, 8'h04};
                5:       r = '{16'd400,  8'h03, 8'h7e, 8'h19, 8'h07, 8'h04};
                6:       r = '{16'd500,  8'h03, 8'h7c, 8'h1b, 8'h07, 8'h08};
                7:       r = '{16'd600,  8'h03, 8'h70, 8'h1d, 8'h08, 8'h10};
                8:       r = '{16'd700,  8'h05, 8'h40, 8'h1e, 8'h08, 8'h30};
                9:       r = '{16'd800,  8'h05, 8'h02, 8'h1f, 8'h09, 8'h30};
                10:      r = '{16'd1000, 8'h05, 8'h08, 8'h20, 8'h09, 8'h30};
                11:      r = '{16'd1400, 8'h09, 8'h03, 8'h32, 8'h14, 8'h0f};
                12:      r = '{16'd1600, 8'h0d, 8'h42, 8'h36, 8'h0e, 8'h0f};
                13:      r = '{16'd1800, 8'h0e, 8'h47, 8'h7a, 8'h0e, 8'h0f};
                default: r = '{16'd2000, 8'h11, 8'h64, 8'h7a, 8'h0e, 8'h0b};
            endcase
        end
        return r;
    endfunction

    // clamp to an all-ones field of width w (w <= 8)
    function automatic logic [7:0] sat_field(input dword_t v, input int w);
        dword_t lim;
        lim = (dword_t'(1) << w) - dword_t'(1);
        return (v > lim) ? lim[7:0] : v[7:0];
    endfunction

endpackage

// File: rtl/dphy_seq_div.sv
module dphy_seq_div #(
    parameter int W = 34
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         fin,
    output logic [W-1:0] quo
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W:0]       rem_q;
    logic [W-1:0]     quo_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic [W:0]       shifted;
    logic             fits;

    always_comb begin
        shifted = {rem_q[W-1:0], quo_q[W-1]};
        fits    = shifted >= {1'b0, den};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            fin   <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                rem_q <= '0;
                quo_q <= num;
                cnt_q <= CNT_W'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= fits ? (shifted - {1'b0, den}) : shifted;
                quo_q <= {quo_q[W-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    run_q <= 1'b0;
                    fin   <= 1'b1;
                end
            end
        end
    end

    assign quo = quo_q;
endmodule

// File: rtl/dphy_rate_lut.sv
module dphy_rate_lut
    import dphy_tc_pkg::*;
#(
    parameter int RATE_W = 12
) (
    input  logic [RATE_W-1:0] rate_i,
    input  logic              alt_i,
    output lut_row_t          row_o
);
    logic [31:0] rate_ext;
    int          rows;
    lut_row_t    cand;

    always_comb begin
        rate_ext = 32'(rate_i);
        rows     = alt_i ? ROWS_ALT : ROWS_BASE;
        row_o    = lut_row(alt_i, rows - 1);
        cand     = row_o;
        // scan from the top so the lowest qualifying row wins
        for (int i = ROWS_MAX - 1; i >= 0; i--) begin
            cand = lut_row(alt_i, i);
            if (i < rows && rate_ext <= 32'(cand.max_rate))
                row_o = cand;
        end
    end
endmodule

// File: rtl/dphy_tc_seq.sv
module dphy_tc_seq
    import dphy_tc_pkg::*;
#(
    parameter int RATE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              kick,
    input  logic [RATE_W-1:0] rate_i,
    output logic              div_go,
    output dword_t            div_num,
    output dword_t            div_den,
    input  logic              div_fin,
    input  dword_t            div_quo,
    output logic              fin,
    output raw_t              res
);
    step_e  step_q;
    dword_t escdiv_q, escclk_q, ui_q, rate_d;

    assign rate_d = dword_t'(rate_i);

    // operand selection per step; every quotient is a ceiling except
    // the escape clock (floor) and the unit interval (nearest)
    always_comb begin
        div_num = '0;
        div_den = dword_t'(1);
        case (step_q)
            ST_ESCDIV: begin
                div_num = rate_d + dword_t'(ESC_LIMIT_MBPS - 1);
                div_den = dword_t'(ESC_LIMIT_MBPS);
            end
            ST_ESCCLK: begin
                div_num = rate_d * dword_t'(BYTE_HZ_PER_MBPS);
                div_den = escdiv_q;
            end
            ST_UI: begin
                div_num = dword_t'(UI_NUM_NS) + (rate_d >> 1);
                div_den = rate_d;
            end
            ST_HSEXIT: begin
                div_num = dword_t'(HS_EXIT_NS) * rate_d + dword_t'(NS_BYTE_DEN - 1);
                div_den = dword_t'(NS_BYTE_DEN);
            end
            ST_CLKPOST: begin
                div_num = (dword_t'(CLK_POST_BASE_NS) + dword_t'(CLK_POST_UI_MULT) * ui_q)
                          * rate_d + dword_t'(NS_BYTE_DEN - 1);
                div_den = dword_t'(NS_BYTE_DEN);
            end
            ST_CLKPRE: begin
                div_num = dword_t'(CLK_PRE_UI_MULT) * ui_q * rate_d + dword_t'(NS_BYTE_DEN - 1);
                div_den = dword_t'(NS_BYTE_DEN);
            end
            ST_LPX: begin
                div_num = dword_t'(LPX_NS) * rate_d + dword_t'(NS_BYTE_DEN - 1);
                div_den = dword_t'(NS_BYTE_DEN);
            end
            ST_TAGO: begin
                div_num = dword_t'(TA_GO_NS) * escclk_q + dword_t'(NS_PER_S - 1);
                div_den = dword_t'(NS_PER_S);
            end
            ST_TASURE: begin
                div_num = dword_t'(TA_SURE_NS) * escclk_q + dword_t'(NS_PER_S - 1);
                div_den = dword_t'(NS_PER_S);
            end
            ST_TAWAIT: begin
                div_num = dword_t'(TA_WAIT_NS) * escclk_q + dword_t'(NS_PER_S - 1);
                div_den = dword_t'(NS_PER_S);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q   <= ST_IDLE;
            div_go   <= 1'b0;
            fin      <= 1'b0;
            escdiv_q <= dword_t'(1);
            escclk_q <= '0;
            ui_q     <= '0;
            res      <= '0;
        end else begin
            div_go <= 1'b0;
            fin    <= 1'b0;
            if (kick && step_q == ST_IDLE) begin
                step_q <= ST_ESCDIV;
                div_go <= 1'b1;
            end else if (div_fin && step_q != ST_IDLE) begin
                case (step_q)
                    ST_ESCDIV:  escdiv_q     <= div_quo;
                    ST_ESCCLK:  escclk_q     <= div_quo;
                    ST_UI:      ui_q         <= div_quo;
                    ST_HSEXIT:  res.hs_exit  <= div_quo;
                    ST_CLKPOST: res.clk_post <= div_quo;
                    ST_CLKPRE:  res.clk_pre  <= div_quo;
                    ST_LPX:     res.lpx      <= div_quo;
                    ST_TAGO:    res.ta_go    <= div_quo;
                    ST_TASURE:  res.ta_sure  <= div_quo;
                    default:    res.ta_wait  <= div_quo;
                endcase
                if (step_q == ST_TAWAIT) begin
                    step_q <= ST_IDLE;
                    fin    <= 1'b1;
                end else begin
                    step_q <= step_e'(step_q + 4'd1);
                    div_go <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dphy_lane_timing.sv
module dphy_lane_timing
    import dphy_tc_pkg::*;
#(
    parameter int RATE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [RATE_W-1:0] rate_mbps_i,
    input  logic              clk_lane_i,
    input  logic              alt_variant_i,
    output logic              done_o,
    output logic [5:0]        lpx_o,
    output logic [6:0]        hs_prepare_o,
    output logic [5:0]        hs_zero_o,
    output logic [6:0]        hs_trail_o,
    output logic [4:0]        hs_exit_o,
    output logic [3:0]        clk_post_o,
    output logic [3:0]        clk_pre_o,
    output logic [1:0]        wakeup_hi_o,
    output logic [7:0]        wakeup_lo_o,
    output logic [5:0]        ta_go_o,
    output logic [5:0]        ta_sure_o,
    output logic [5:0]        ta_wait_o
);
    logic              busy_q, kick_q, lane_q, alt_q, accept;
    logic [RATE_W-1:0] rate_q;
    logic              div_go, div_fin, seq_fin;
    dword_t            div_num, div_den, div_quo, lpx_pick;
    raw_t              res;
    lut_row_t          row;

    assign accept = start_i && !busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            kick_q <= 1'b0;
            rate_q <= '0;
            lane_q <= 1'b0;
            alt_q  <= 1'b0;
        end else begin
            kick_q <= accept;
            if (accept) begin
                rate_q <= (rate_mbps_i == '0) ? RATE_W'(1) : rate_mbps_i;
                lane_q <= clk_lane_i;
                alt_q  <= alt_variant_i;
                busy_q <= 1'b1;
            end else if (seq_fin) begin
                busy_q <= 1'b0;
            end
        end
    end

    dphy_rate_lut #(.RATE_W(RATE_W)) u_lut (
        .rate_i (rate_q),
        .alt_i  (alt_q),
        .row_o  (row)
    );

    dphy_tc_seq #(.RATE_W(RATE_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .kick    (kick_q),
        .rate_i  (rate_q),
        .div_go  (div_go),
        .div_num (div_num),
        .div_den (div_den),
        .div_fin (div_fin),
        .div_quo (div_quo),
        .fin     (seq_fin),
        .res     (res)
    );

    dphy_seq_div #(.W(DIV_W)) u_div (
        .clk (clk),
        .rst (rst),
        .go  (div_go),
        .num (div_num),
        .den (div_den),
        .fin (div_fin),
        .quo (div_quo)
    );

    // variant 1 reads lpx from its table; variant 0 trims the computed count
    always_comb begin
        if (alt_q)
            lpx_pick = dword_t'(row.lpx);
        else if (res.lpx > dword_t'(LPX_TRIM))
            lpx_pick = res.lpx - dword_t'(LPX_TRIM);
        else
            lpx_pick = res.lpx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o       <= 1'b0;
            lpx_o        <= '0;
            hs_prepare_o <= '0;
            hs_zero_o    <= '0;
            hs_trail_o   <= '0;
            hs_exit_o    <= '0;
            clk_post_o   <= '0;
            clk_pre_o    <= '0;
            ta_go_o      <= '0;
            ta_sure_o    <= '0;
            ta_wait_o    <= '0;
        end else begin
            done_o <= seq_fin;
            if (seq_fin) begin
                lpx_o        <= W_LPX'(sat_field(lpx_pick, W_LPX));
                hs_prepare_o <= W_PREP'(sat_field(dword_t'(row.prep), W_PREP));
                hs_zero_o    <= W_ZERO'(sat_field(dword_t'(lane_q ? row.zero_clk
                                                                  : row.zero_data), W_ZERO));
                hs_trail_o   <= W_TRAIL'(sat_field(dword_t'(row.trail), W_TRAIL));
                hs_exit_o    <= W_EXIT'(sat_field(res.hs_exit, W_EXIT));
                clk_post_o   <= W_POST'(sat_field(res.clk_post, W_POST));
                clk_pre_o    <= W_PRE'(sat_field(res.clk_pre, W_PRE));
                ta_go_o      <= W_TA'(sat_field(res.ta_go, W_TA));
                ta_sure_o    <= W_TA'(sat_field(res.ta_sure, W_TA));
                ta_wait_o    <= W_TA'(sat_field(res.ta_wait, W_TA));
            end
        end
    end

    assign wakeup_hi_o = WAKE_HI_VAL;
    assign wakeup_lo_o = WAKE_LO_VAL;
endmodule

// File: rtl/dphy_lane_timing_chk.sv
module dphy_lane_timing_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       busy_q,
    input logic       done_o,
    input logic [5:0] lpx_o,
    input logic [6:0] hs_prepare_o,
    input logic [5:0] hs_zero_o,
    input logic [6:0] hs_trail_o,
    input logic [4:0] hs_exit_o,
    input logic [3:0] clk_post_o,
    input logic [3:0] clk_pre_o,
    input logic [5:0] ta_go_o,
    input logic [5:0] ta_sure_o,
    input logic [5:0] ta_wait_o
);
    // R10: single-cycle done
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R10: an accepted start cannot complete on the next cycle
    assert_no_instant_done_R10: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_q) |=> !done_o);

    // R10: fields only move together with done
    assert_hold_between_R10: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable({lpx_o, hs_prepare_o, hs_zero_o, hs_trail_o, hs_exit_o,
                             clk_post_o, clk_pre_o, ta_go_o, ta_sure_o, ta_wait_o}));

    // R2: turnaround counts ordered by their nanosecond minimums
    assert_ta_order_R2: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (ta_sure_o <= ta_go_o) && (ta_go_o <= ta_wait_o));

    // R2: escape clock never above 20 MHz bounds the wait count
    assert_esc_bound_R2: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (ta_wait_o <= 6'd6));

    // R4: post time always exceeds pre time
    assert_post_ge_pre_R4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (clk_post_o >= clk_pre_o));
endmodule

bind dphy_lane_timing dphy_lane_timing_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .busy_q       (busy_q),
    .done_o       (done_o),
    .lpx_o        (lpx_o),
    .hs_prepare_o (hs_prepare_o),
    .hs_zero_o    (hs_zero_o),
    .hs_trail_o   (hs_trail_o),
    .hs_exit_o    (hs_exit_o),
    .clk_post_o   (clk_post_o),
    .clk_pre_o    (clk_pre_o),
    .ta_go_o      (ta_go_o),
    .ta_sure_o    (ta_sure_o),
    .ta_wait_o    (ta_wait_o)
);

// File: tb/tb_dphy_lane_timing.sv
module tb_dphy_lane_timing;

    typedef struct packed {
        logic [11:0] rate;
        logic        lane;
        logic        alt;
        logic [7:0]  lpx;
        logic [7:0]  prep;
        logic [7:0]  zero;
        logic [7:0]  trail;
        logic [7:0]  hexit;
        logic [7:0]  post;
        logic [7:0]  pre;
        logic [7:0]  go;
        logic [7:0]  sure;
        logic [7:0]  wt;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{12'd100,  1'b0, 1'b0, 8'd1,  8'h20, 8'h02, 8'h22, 8'd2,  8'd8,  8'd1, 8'd3, 8'd2, 8'd4},
        '{12'd480,  1'b1, 1'b0, 8'd2,  8'h20, 8'h1b, 8'h4e, 8'd8,  8'd11, 8'd1, 8'd5, 8'd3, 8'd6},
        '{12'd1000, 1'b0, 1'b1, 8'd5,  8'h08, 8'h09, 8'h30, 8'd15, 8'd15, 8'd1, 8'd5, 8'd3, 8'd6},
        '{12'd1900, 1'b1, 1'b1, 8'd17, 8'h64, 8'd63, 8'h0b, 8'd29, 8'd15, 8'd2, 8'd5, 8'd3, 8'd6},
        '{12'd3000, 1'b0, 1'b1, 8'd17, 8'h64, 8'h0e, 8'h0b, 8'd31, 8'd15, 8'd0, 8'd5, 8'd3, 8'd6},
        '{12'd2000, 1'b0, 1'b0, 8'd13, 8'h09, 8'h09, 8'h27, 8'd30, 8'd15, 8'd2, 8'd5, 8'd3, 8'd6},
        '{12'd160,  1'b0, 1'b0, 8'd2,  8'h18, 8'h04, 8'h0b, 8'd3,  8'd8,  8'd1, 8'd5, 8'd3, 8'd6},
        '{12'd110,  1'b1, 1'b1, 8'd2,  8'h7f, 8'h16, 8'h02, 8'd2,  8'd8,  8'd1, 8'd4, 8'd2, 8'd5},
        '{12'd0,    1'b0, 1'b0, 8'd1,  8'h20, 8'h02, 8'h22, 8'd1,  8'd7,  8'd1, 8'd1, 8'd1, 8'd1},
        '{12'd3000, 1'b0, 1'b0, 8'd21, 8'h09, 8'h09, 8'h27, 8'd31, 8'd15, 8'd0, 8'd5, 8'd3, 8'd6},
        '{12'd111,  1'b0, 1'b0, 8'd1,  8'h06, 8'h03, 8'h45, 8'd2,  8'd8,  8'd1, 8'd4, 8'd2, 8'd5}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [11:0] rate = '0;
    logic        lane = 1'b0;
    logic        alt = 1'b0;
    logic        done;
    logic [5:0]  lpx, hzero, tgo, tsure, twait;
    logic [6:0]  prep, trail;
    logic [4:0]  hexit;
    logic [3:0]  post, pre;
    logic [1:0]  wh;
    logic [7:0]  wl;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dphy_lane_timing #(.RATE_W(12)) dut (
        .clk(clk), .rst(rst), .start_i(start), .rate_mbps_i(rate),
        .clk_lane_i(lane), .alt_variant_i(alt), .done_o(done),
        .lpx_o(lpx), .hs_prepare_o(prep), .hs_zero_o(hzero), .hs_trail_o(trail),
        .hs_exit_o(hexit), .clk_post_o(post), .clk_pre_o(pre),
        .wakeup_hi_o(wh), .wakeup_lo_o(wl),
        .ta_go_o(tgo), .ta_sure_o(tsure), .ta_wait_o(twait)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    // drive a request and wait until done is seen at a falling edge
    task automatic launch(input logic [11:0] r, input logic l, input logic a);
        @(negedge clk);
        rate = r; lane = l; alt = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (done !== 1'b1 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(req, "done seen", int'(done === 1'b1), 1);
    endtask

    task automatic check_vec(input vec_t v);
        string lreq;
        lreq = v.alt ? "R6" : "R5";
        chk(lreq, "lpx",        int'(lpx),   int'(v.lpx));
        chk("R6", "hs_prepare", int'(prep),  int'(v.prep));
        chk("R7", "hs_zero",    int'(hzero), int'(v.zero));
        chk("R6", "hs_trail",   int'(trail), int'(v.trail));
        chk("R3", "hs_exit",    int'(hexit), int'(v.hexit));
        chk("R4", "clk_post",   int'(post),  int'(v.post));
        chk("R4", "clk_pre",    int'(pre),   int'(v.pre));
        chk("R2", "ta_go",      int'(tgo),   int'(v.go));
        chk("R2", "ta_sure",    int'(tsure), int'(v.sure));
        chk("R2", "ta_wait",    int'(twait), int'(v.wt));
    endtask

    initial begin
        int dcount;
        repeat (4) @(negedge clk);
        // R1: fields held at zero during reset
        chk("R1", "done in reset", int'(done), 0);
        chk("R1", "fields in reset", int'({lpx, prep, hzero, trail, hexit, post, pre, tgo, tsure, twait}), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "fields after reset", int'({lpx, prep, hzero, trail, hexit, post, pre, tgo, tsure, twait}), 0);
        chk("R1", "done after reset", int'(done), 0);
        // R9: constant wakeup fields
        chk("R9", "wakeup_hi", int'(wh), 3);
        chk("R9", "wakeup_lo", int'(wl), 255);

        for (int i = 0; i < NV; i++) begin
            launch(VECS[i].rate, VECS[i].lane, VECS[i].alt);
            wait_done("R10");
            check_vec(VECS[i]);
            @(negedge clk);
            chk("R10", "done one cycle", int'(done), 0);
        end

        // R8: saturated fields from a rate past every row
        launch(12'd3000, 1'b1, 1'b1);
        wait_done("R8");
        chk("R8", "hs_zero sat", int'(hzero), 63);
        chk("R8", "hs_exit sat", int'(hexit), 31);
        chk("R8", "clk_post sat", int'(post), 15);

        // R11: rate 0 behaves like rate 1
        launch(12'd1, 1'b0, 1'b0);
        wait_done("R11");
        check_vec(VECS[8]);
        chk("R11", "rate1 clk_post", int'(post), 7);

        // R10: start during a calculation is ignored
        launch(12'd100, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        rate = 12'd2000; alt = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R10");
        chk("R10", "mid-run start ignored hs_exit", int'(hexit), 2);
        chk("R10", "mid-run start ignored ta_wait", int'(twait), 4);
        dcount = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (done) dcount++;
        end
        chk("R10", "no extra done", dcount, 0);
        chk("R10", "outputs held hs_exit", int'(hexit), 2);
        chk("R10", "outputs held clk_post", int'(post), 8);
        chk("R9", "wakeup_lo after runs", int'(wl), 255);

        if (!finished) begin
            finished = 1'b1;
            summary();
        end
    end
endmodule